// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Controller

This block keeps the status flags of a byte-wide SPI peripheral and turns them into CPU interrupt requests. It sits between a CPU register bus (read and write strobes, a two-bit register select, a data byte each way) and a serial shift engine. The shift engine reports its events to the block as single-cycle pulses: a received byte is ready, or the shifter has taken the pending transmit byte. It also reports a level that is high while a transfer is in progress. The block buffers one received byte and one byte waiting for transmission.

Four flags are kept: receive buffer full, transmit buffer empty, overrun, and mode fault. Each flag that software clears needs two accesses. First a status read must see the flag set, which arms it. Then a specific second access clears it: a data read for the two receive flags, or a control write for mode fault. On an overrun the byte already buffered is kept and the new byte is dropped. Mode fault is detected on the SS level, and the condition differs between master and slave mode. When the block is a master and fault detection is off, it tells the pad logic that SS is free for general use.

Top module: `spi_flag_ctl`

## Requirements
- R1: Register select encoding: 0 = control, 1 = status, 2 = data (reading returns the receive buffer, writing loads the transmit buffer). `bus_rdata` always shows the selected register. Only `bus_rd`/`bus_wr` cause side effects. Control bits [3:0] are {fault detect enable, error irq enable, transmit irq enable, receive irq enable}. Status bits [3:0] are {mode fault, overrun, transmit empty, receive full}. Upper bits read as zero.
- R2: A received-byte pulse while the receive buffer is not full loads the byte and sets receive full on the next cycle.
- R3: Receive full is cleared by a status read that sees it set, followed by a data read. A data read without that armed status read leaves it set.
- R4: A received-byte pulse while receive full is set (and not being cleared in that cycle) sets overrun and leaves the buffered byte unchanged.
- R5: Overrun is cleared by the same sequence: a status read that sees it set, then a data read.
- R6: With fault detection enabled, a slave sets mode fault when SS is high while a transfer is active.
- R7: With fault detection enabled, a master sets mode fault whenever SS is low. With detection disabled, no fault is raised.
- R8: Mode fault is cleared by a status read that sees it set, followed by a control write. Clearing the detection enable on its own does not clear the flag.
- R9: Transmit empty is set by reset and by the shifter taking the pending byte. A data write while it is set stores the byte and clears it. A data write while it is clear is ignored, and the pending byte is kept.
- R10: The receive irq is receive full AND its enable. The transmit irq is transmit empty AND its enable. The error irq is (overrun OR mode fault) AND the error enable.
- R11: `ss_gpio_free` is high exactly when the block is a master and fault detection is disabled.
- R12: A status read arms a flag's clear only if that flag is set at the time of the read. A flag that sets after the read is not cleared by the following data access.
- R13: After reset the control register is 0, status reads 0x02, the receive buffer is 0 and all irqs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select (0 control, 1 status, 2 data) |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| eng_rx_done | input | 1 | Shift engine finished receiving a byte |
| eng_rx_byte | input | DATA_W | Byte received by the shift engine |
| eng_tx_load | input | 1 | Shift engine took the pending transmit byte |
| eng_busy | input | 1 | Transfer in progress |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| ss_in | input | 1 | SS pin level |
| tx_byte | output | DATA_W | Pending transmit byte for the shift engine |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |
| ss_gpio_free | output | 1 | SS pin may be used as a general-purpose pin |

## Verification
The hardest situation to reach is a flag that becomes set after the status read that began its clear sequence. The bench produces it by reading status while receive full is clear, then delivering a byte, then issuing the data read. The flag must survive this. A second case is an overrun followed by one armed data read: the bench checks that this single read clears receive full and overrun together, and that the earlier byte was the one kept. For mode fault, the bench holds SS and the transfer level for exactly one cycle, then changes the enable. This shows that the flag is sticky and that only the armed control write clears it.

// File: rtl/spi_flag_pkg.sv
// Package: shared types for the SPI status flag controller.
// Assumes the register select is two bits and that the control and
// status registers use only the low four bits of a data byte.
package spi_flag_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control register, bit 0 first from the right
    typedef struct packed {
        logic fault_en;
        logic err_ie;
        logic tx_ie;
        logic rx_ie;
    } ctrl_t;

    // Status register, bit 0 first from the right
    typedef struct packed {
        logic mode_fault;
        logic overrun;
        logic tx_empty;
        logic rx_full;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/spi_rx_path.sv
// Module: receive buffer with the receive-full and overrun flags.
// Holds one received byte. A new byte while full raises overrun and is
// dropped. Both flags clear through an armed status read followed by a
// data read. Assumes stat_rd and data_rd are never high together.
module spi_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data
);

    logic arm_full;
    logic arm_ovr;
    logic clr_full;
    logic clr_ovr;
    logic accept;

    assign clr_full = data_rd & arm_full;
    assign clr_ovr  = data_rd & arm_ovr;
    assign accept   = rx_done & (~rx_full | clr_full);

    // Arm bits remember the first step of each clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_full <= 1'b0;
            arm_ovr  <= 1'b0;
        end else if (stat_rd) begin
            arm_full <= rx_full;
            arm_ovr  <= overrun;
        end else if (data_rd) begin
            arm_full <= 1'b0;
            arm_ovr  <= 1'b0;
        end
    end

    // Receive buffer and full flag: load when empty or being emptied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_data <= '0;
        end else if (accept) begin
            rx_full <= 1'b1;
            rx_data <= rx_byte;
        end else if (clr_full) begin
            rx_full <= 1'b0;
        end
    end

    // Overrun flag: set on a dropped byte, cleared by armed data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (rx_done && !accept) begin
            overrun <= 1'b1;
        end else if (clr_ovr) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_tx_path.sv
// Module: transmit buffer with the transmit-empty flag.
// A data write is taken only while the buffer is empty. The shift engine
// empties it with a load pulse. Assumes the engine pulses load only while
// a byte is pending; a load pulse while empty is ignored.
module spi_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_load,
    output logic              tx_empty,
    output logic [DATA_W-1:0] tx_byte
);

    // Buffer fill by the bus, drain by the shift engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b1;
            tx_byte  <= '0;
        end else if (tx_empty) begin
            if (data_wr) begin
                tx_empty <= 1'b0;
                tx_byte  <= wdata;
            end
        end else if (tx_load) begin
            tx_empty <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_mode_fault.sv
// Module: mode fault detector and flag.
// A slave faults on SS high during a transfer. A master faults on SS low
// at any time. Both need detection enabled. The flag is sticky and
// clears only through an armed status read followed by a control write.
// A fault condition in the clearing cycle wins over the clear.
module spi_mode_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic ctrl_wr,
    input  logic fault_en,
    input  logic is_master,
    input  logic ss_in,
    input  logic busy,
    output logic mode_fault
);

    logic arm;
    logic fault_now;

    assign fault_now = fault_en & (is_master ? ~ss_in : (ss_in & busy));

    // Arm bit for the two-step clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
        end else if (stat_rd) begin
            arm <= mode_fault;
        end else if (ctrl_wr) begin
            arm <= 1'b0;
        end
    end

    // Sticky fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_fault <= 1'b0;
        end else if (fault_now) begin
            mode_fault <= 1'b1;
        end else if (ctrl_wr && arm) begin
            mode_fault <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_flag_ctl.sv
// Module: top of the SPI status flag and interrupt controller.
// Decodes bus accesses into side-effect strobes and holds the control
// register. Muxes read data and forms the interrupt requests. Assumes
// single-cycle bus strobes, and DATA_W no smaller than the control and
// status widths.
module spi_flag_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_rx_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_tx_load,
    input  logic              eng_busy,
    input  logic              is_master,
    input  logic              ss_in,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_err,
    output logic              ss_gpio_free
);
    import spi_flag_pkg::*;

    localparam int CW = CTRL_W;
    localparam int SW = STAT_W;

    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    stat_t             stat;
    logic              stat_rd;
    logic              data_rd;
    logic              data_wr;
    logic              ctrl_wr;
    logic [DATA_W-1:0] rx_data;

    assign sel     = reg_sel_e'(bus_sel);
    assign stat_rd = bus_rd & (sel == SEL_STAT);
    assign data_rd = bus_rd & (sel == SEL_DATA);
    assign data_wr = bus_wr & (sel == SEL_DATA);
    assign ctrl_wr = bus_wr & (sel == SEL_CTRL);

    // Control register written by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[CW-1:0]);
        end
    end

    spi_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .rx_done (eng_rx_done),
        .rx_byte (eng_rx_byte),
        .rx_full (stat.rx_full),
        .overrun (stat.overrun),
        .rx_data (rx_data)
    );

    spi_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .wdata    (bus_wdata),
        .tx_load  (eng_tx_load),
        .tx_empty (stat.tx_empty),
        .tx_byte  (tx_byte)
    );

    spi_mode_fault u_mf (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .ctrl_wr    (ctrl_wr),
        .fault_en   (ctrl_q.fault_en),
        .is_master  (is_master),
        .ss_in      (ss_in),
        .busy       (eng_busy),
        .mode_fault (stat.mode_fault)
    );

    // Read data mux, free of side effects
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata[CW-1:0] = ctrl_q;
            SEL_STAT: bus_rdata[SW-1:0] = stat;
            SEL_DATA: bus_rdata         = rx_data;
            default:  bus_rdata         = '0;
        endcase
    end

    // Interrupt requests and SS release
    assign irq_rx       = stat.rx_full & ctrl_q.rx_ie;
    assign irq_tx       = stat.tx_empty & ctrl_q.tx_ie;
    assign irq_err      = (stat.overrun | stat.mode_fault) & ctrl_q.err_ie;
    assign ss_gpio_free = is_master & ~ctrl_q.fault_en;

endmodule

// File: rtl/spi_flag_chk.sv
// Module: assertion checker for spi_flag_ctl, attached by bind.
// Assumes it sees the top's ports and its internal flag state.
module spi_flag_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_sel,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              eng_rx_done,
    input logic              eng_tx_load,
    input logic              eng_busy,
    input logic              is_master,
    input logic              ss_in,
    input logic              fault_en,
    input logic              rx_full,
    input logic              overrun,
    input logic              tx_empty,
    input logic              mode_fault,
    input logic [DATA_W-1:0] rx_data,
    input logic [DATA_W-1:0] tx_byte
);

    logic data_rd;
    logic data_wr;
    logic ctrl_wr;
    assign data_rd = bus_rd && bus_sel == 2'd2;
    assign data_wr = bus_wr && bus_sel == 2'd2;
    assign ctrl_wr = bus_wr && bus_sel == 2'd0;

    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_done |=> rx_full);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_done && rx_full && !data_rd) |=> (overrun && $stable(rx_data)));

    assert_slave_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_en && !is_master && ss_in && eng_busy) |=> mode_fault);

    assert_master_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_en && is_master && !ss_in) |=> mode_fault);

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !ctrl_wr) |=> mode_fault);

    assert_tx_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_load && !tx_empty) |=> tx_empty);

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_empty) |=> $stable(tx_byte));

    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !data_rd) |=> rx_full);

endmodule

bind spi_flag_ctl spi_flag_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .eng_rx_done (eng_rx_done),
    .eng_tx_load (eng_tx_load),
    .eng_busy    (eng_busy),
    .is_master   (is_master),
    .ss_in       (ss_in),
    .fault_en    (ctrl_q.fault_en),
    .rx_full     (stat.rx_full),
    .overrun     (stat.overrun),
    .tx_empty    (stat.tx_empty),
    .mode_fault  (stat.mode_fault),
    .rx_data     (rx_data),
    .tx_byte     (tx_byte)
);

// File: tb/sim_spi_flag_ctl.sv
`timescale 1ns/1ps
module sim_spi_flag_ctl;

    localparam int DW = 8;
    localparam int NV = 16;
    // Vector: {kind[2:0], sel[1:0], data[7:0], expected status[3:0]}
    // kind: 1 bus read, 2 bus write, 3 received byte, 4 shifter load
    localparam logic [16:0] VEC [NV] = '{
        {3'd3, 2'd2, 8'hA5, 4'b0011},
        {3'd1, 2'd2, 8'h00, 4'b0011},
        {3'd1, 2'd1, 8'h00, 4'b0011},
        {3'd1, 2'd2, 8'h00, 4'b0010},
        {3'd3, 2'd2, 8'h3C, 4'b0011},
        {3'd3, 2'd2, 8'h77, 4'b0111},
        {3'd1, 2'd1, 8'h00, 4'b0111},
        {3'd1, 2'd2, 8'h00, 4'b0010},
        {3'd2, 2'd2, 8'h5A, 4'b0000},
        {3'd2, 2'd2, 8'h99, 4'b0000},
        {3'd4, 2'd0, 8'h00, 4'b0010},
        {3'd1, 2'd1, 8'h00, 4'b0010},
        {3'd3, 2'd2, 8'h11, 4'b0011},
        {3'd1, 2'd2, 8'h00, 4'b0011},
        {3'd1, 2'd1, 8'h00, 4'b0011},
        {3'd1, 2'd2, 8'h00, 4'b0010}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_sel = 2'd1;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          eng_rx_done = 1'b0;
    logic [DW-1:0] eng_rx_byte = '0;
    logic          eng_tx_load = 1'b0;
    logic          eng_busy = 1'b0;
    logic          is_master = 1'b0;
    logic          ss_in = 1'b1;
    logic [DW-1:0] tx_byte;
    logic          irq_rx, irq_tx, irq_err, ss_gpio_free;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_flag_ctl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_rx_done(eng_rx_done), .eng_rx_byte(eng_rx_byte),
        .eng_tx_load(eng_tx_load), .eng_busy(eng_busy),
        .is_master(is_master), .ss_in(ss_in), .tx_byte(tx_byte),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err),
        .ss_gpio_free(ss_gpio_free)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation for one clock, then idle with status shown on rdata
    task automatic op(input logic [2:0] kind, input logic [1:0] sel,
                      input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel     = sel;
        bus_rd      = (kind == 3'd1);
        bus_wr      = (kind == 3'd2);
        bus_wdata   = d;
        eng_rx_done = (kind == 3'd3);
        eng_rx_byte = d;
        eng_tx_load = (kind == 3'd4);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; eng_rx_done = 1'b0;
        eng_tx_load = 1'b0; bus_sel = 2'd1;
        #1;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [DW-1:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
        bus_sel = 2'd1;
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    function automatic string req_of(input int i);
        case (i)
            0: return "R2 byte loads";
            1: return "R3 unarmed data read";
            2, 3: return "R3 armed clear";
            4: return "R2 reload";
            5: return "R4 overrun set";
            6, 7: return "R5 overrun clear";
            8: return "R9 write clears empty";
            9: return "R9 write ignored";
            10: return "R9 shifter load";
            11, 12, 13: return "R12 arm only when set";
            default: return "R3 rearmed clear";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] v;
        do_reset();

        // Vector table walk (status fields per R1)
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][16:14], VEC[i][13:12], VEC[i][11:4]);
            check(req_of(i), bus_rdata, {4'b0, VEC[i][3:0]});
        end

        // R13: reset state
        do_reset();
        check("R13 status", bus_rdata, 8'h02);
        peek(2'd0, v); check("R13 control", v, 8'h00);
        peek(2'd2, v); check("R13 rx buffer", v, 8'h00);
        check("R13 irqs", {5'b0, irq_rx, irq_tx, irq_err}, 8'h00);

        // R4: overrun keeps earlier byte
        op(3'd3, 2'd2, 8'h3C);
        op(3'd3, 2'd2, 8'h77);
        peek(2'd2, v); check("R4 kept byte", v, 8'h3C);
        check("R4 status", bus_rdata, 8'h07);

        // R1, R10: control readback and irqs
        op(3'd2, 2'd0, 8'h05);
        peek(2'd0, v); check("R1 control readback", v, 8'h05);
        check("R10 rx and err irq", {6'b0, irq_rx, irq_err}, 8'h03);

        // R9: pending byte protected from a second write
        op(3'd2, 2'd2, 8'h5A);
        op(3'd2, 2'd2, 8'h99);
        check("R9 pending byte", tx_byte, 8'h5A);
        op(3'd2, 2'd0, 8'h02);
        check("R10 tx irq off while full", {7'b0, irq_tx}, 8'h00);
        op(3'd4, 2'd0, 8'h00);
        check("R10 tx irq on empty", {7'b0, irq_tx}, 8'h01);

        // R6, R8: slave mode fault, sticky, armed clear
        do_reset();
        op(3'd2, 2'd0, 8'h0C);
        check("R6 no fault while idle", bus_rdata, 8'h02);
        @(negedge clk); eng_busy = 1'b1;
        @(negedge clk); eng_busy = 1'b0; #1;
        check("R6 slave fault", bus_rdata, 8'h0A);
        check("R10 err irq on fault", {7'b0, irq_err}, 8'h01);
        op(3'd2, 2'd0, 8'h04);
        check("R8 disable keeps flag", bus_rdata, 8'h0A);
        op(3'd1, 2'd1, 8'h00);
        op(3'd2, 2'd0, 8'h04);
        check("R8 armed clear", bus_rdata, 8'h02);

        // R7, R11: master fault and SS release
        is_master = 1'b1;
        #1;
        check("R11 ss free", {7'b0, ss_gpio_free}, 8'h01);
        ss_in = 1'b0;
        op(3'd0, 2'd1, 8'h00);
        check("R7 disabled no fault", bus_rdata, 8'h02);
        op(3'd2, 2'd0, 8'h08);
        op(3'd0, 2'd1, 8'h00);
        check("R7 master fault", bus_rdata, 8'h0A);
        check("R11 ss held", {7'b0, ss_gpio_free}, 8'h00);
        ss_in = 1'b1;
        op(3'd1, 2'd1, 8'h00);
        op(3'd2, 2'd0, 8'h08);
        check("R8 master clear", bus_rdata, 8'h02);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule